// File: doc/BRIEF.md
# Two-Level Look-Up-Table Logic Cell

This block is one programmable logic cell. Two 4-input look-up tables (the F table and the G table) each compute any Boolean function of their own four inputs. A 3-input look-up table (the H table) sits behind them. Two of its address bits can each be steered either to a first-level table output or to a direct cell pin. The third address bit always comes from a direct pin. Two edge-triggered registers, each with its own clock enable, capture either the H table output or one of the first-level outputs.

All table contents and steering choices sit in one serial configuration chain. A host shifts this chain in while the cell is held in configuration mode. Once the configuration enable falls, the cell computes the loaded function, and it can be reloaded at any time. With the H table programmed as a 2:1 multiplexer whose select is the dedicated pin, the cell realises any function of five inputs. The three combinational table outputs are exposed next to the registered outputs.

Top module: `lut_cell`

## Requirements
- R1: `f_out` equals configuration bit `cfg[f_in]`, where the F table occupies chain bits 15..0 and the address `f_in` is read as an unsigned number.
- R2: `g_out` equals configuration bit `cfg[16 + g_in]`; the G table occupies chain bits 31..16.
- R3: `h_out` equals `cfg[32 + {a2, a1, h_in[0]}]`. Here `a1` is `f_out` when chain bit 40 is 1 and `h_in[1]` when it is 0. `a2` is `g_out` when chain bit 41 is 1 and `h_in[2]` when it is 0.
- R4: With chain bits 40 and 41 set and the H table loaded as a multiplexer that picks `a2` when `h_in[0]` is 1 and `a1` otherwise, `h_out` realises any 32-entry truth table over `{h_in[0], x[3:0]}`, with `f_in = g_in = x`.
- R5: While `cfg_en` is high, each rising edge of `cfg_clk` shifts `cfg_din` into chain bit 0 and moves every bit up one place. Shifting a 44-bit word most-significant bit first therefore places word bit k at chain bit k.
- R6: While `cfg_en` is low, `cfg_din` has no effect and the loaded function stays unchanged.
- R7: Register `q[i]` takes `h_out` when its source bit (chain bit 42 for `q[0]`, bit 43 for `q[1]`) is 1. Otherwise it takes `f_out` (for `q[0]`) or `g_out` (for `q[1]`).
- R8: With `cfg_en` low, `q[i]` loads its input on a rising `clk` edge only when `ce[i]` is 1, and holds otherwise.
- R9: While `cfg_en` is high, both registers hold their value whatever `ce` is.
- R10: A synchronous active-high `rst` clears both registers to 0 on the next rising `clk` edge, with priority over everything else.
- R11: The chain can be reloaded any number of times, and each load fully replaces the previous function.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for the registers |
| rst | input | 1 | Synchronous active-high reset of the registers |
| cfg_clk | input | 1 | Configuration shift clock |
| cfg_en | input | 1 | Configuration mode; the chain shifts and the registers hold |
| cfg_din | input | 1 | Serial configuration data, most-significant bit first |
| f_in | input | 4 | Address of the F table |
| g_in | input | 4 | Address of the G table |
| h_in | input | 3 | Direct H table pins; bit 0 is the dedicated input |
| ce | input | 2 | Per-register clock enables |
| f_out | output | 1 | F table output |
| g_out | output | 1 | G table output |
| h_out | output | 1 | H table output |
| q | output | 2 | Registered outputs |

## Verification
Random configuration words are loaded, and each one is driven with random addresses. The random steering bits mean every load uses either the table-fed or the pin-fed path for the H table, so a swapped steering multiplexer shows up as a mismatch. A chain with a single set bit pins down the shift order and bit positions. An exhaustive sweep of all 32 input combinations on a random five-input truth table tells a correct H address order apart from a reversed one. Random clock enables, together with loads that run while both enables are high, separate the enable gating from the configuration-mode hold. Toggling the serial data pin with the enable low shows whether stray shifting occurs.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;
   localparam int unsigned DEF_FLUT_IN = 4;
   localparam int unsigned DEF_HLUT_IN = 3;
   localparam int unsigned NUM_REG     = 2;
   localparam int unsigned NUM_STEER   = 2;

   function automatic int unsigned tbl_bits(input int unsigned n);
      return 32'd1 << n;
   endfunction

   function automatic int unsigned chain_width(input int unsigned fn, input int unsigned hn);
      return 2 * tbl_bits(fn) + tbl_bits(hn) + NUM_STEER + NUM_REG;
   endfunction
endpackage

// File: rtl/cfg_chain.sv
module cfg_chain #(
   parameter int unsigned W = 44
) (
   input  logic         cfg_clk,
   input  logic         cfg_en,
   input  logic         cfg_din,
   output logic [W-1:0] cfg
);
   generate
      if (W < 2) begin : g_bad_w
         $error("cfg_chain: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge cfg_clk) begin
      if (cfg_en) cfg <= {cfg[W-2:0], cfg_din};
   end

   // R6
   cfg_hold_chk: assert property (@(posedge cfg_clk) !cfg_en |=> $stable(cfg));
endmodule

// File: rtl/lut_table.sv
module lut_table #(
   parameter int unsigned N        = 4,
   parameter bit          MUX_TREE = 1'b1
) (
   input  logic [(1<<N)-1:0] tbl,
   input  logic [N-1:0]      addr,
   output logic              dout
);
   localparam int unsigned ENTRIES = 1 << N;

   generate
      if (N < 1 || N > 6) begin : g_bad_n
         $error("lut_table: N out of range 1..6");
      end
      if (MUX_TREE) begin : g_tree
         logic [2*ENTRIES-1:1] node;
         for (genvar i = 0; i < ENTRIES; i++) begin : g_leaf
            assign node[ENTRIES + i] = tbl[i];
         end
         for (genvar d = 0; d < N; d++) begin : g_lvl
            for (genvar j = 0; j < (1 << d); j++) begin : g_node
               localparam int unsigned K = (1 << d) + j;
               assign node[K] = addr[N-1-d] ? node[2*K+1] : node[2*K];
            end
         end
         assign dout = node[1];
      end else begin : g_index
         assign dout = tbl[addr];
      end
   endgenerate
endmodule

// File: rtl/cell_reg.sv
module cell_reg (
   input  logic clk,
   input  logic rst,
   input  logic hold,
   input  logic ce,
   input  logic d,
   output logic q
);
   always_ff @(posedge clk) begin
      if (rst)              q <= 1'b0;
      else if (!hold && ce) q <= d;
   end

   // R10
   reset_clear_chk: assert property (@(posedge clk) rst |=> !q);
   // R8
   ce_hold_chk: assert property (@(posedge clk) disable iff (rst) (!hold && !ce) |=> $stable(q));
   // R8
   ce_load_chk: assert property (@(posedge clk) disable iff (rst) (!hold && ce) |=> (q == $past(d)));
   // R9
   cfg_hold_q_chk: assert property (@(posedge clk) disable iff (rst) hold |=> $stable(q));
endmodule

// File: rtl/lut_cell.sv
module lut_cell
   import lut_cell_pkg::*;
#(
   parameter int unsigned FLUT_IN  = DEF_FLUT_IN,
   parameter int unsigned HLUT_IN  = DEF_HLUT_IN,
   parameter bit          MUX_TREE = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               cfg_clk,
   input  logic               cfg_en,
   input  logic               cfg_din,
   input  logic [FLUT_IN-1:0] f_in,
   input  logic [FLUT_IN-1:0] g_in,
   input  logic [HLUT_IN-1:0] h_in,
   input  logic [NUM_REG-1:0] ce,
   output logic               f_out,
   output logic               g_out,
   output logic               h_out,
   output logic [NUM_REG-1:0] q
);
   localparam int unsigned FBITS  = tbl_bits(FLUT_IN);
   localparam int unsigned HBITS  = tbl_bits(HLUT_IN);
   localparam int unsigned CW     = chain_width(FLUT_IN, HLUT_IN);
   localparam int unsigned F_LO   = 0;
   localparam int unsigned G_LO   = F_LO + FBITS;
   localparam int unsigned H_LO   = G_LO + FBITS;
   localparam int unsigned STR_LO = H_LO + HBITS;
   localparam int unsigned SRC_LO = STR_LO + NUM_STEER;

   generate
      if (HLUT_IN < 3) begin : g_bad_h
         $error("lut_cell: HLUT_IN must be at least 3");
      end
      if (NUM_REG != 2) begin : g_bad_reg
         $error("lut_cell: exactly two registers supported");
      end
   endgenerate

   logic [CW-1:0]      cfg;
   logic [HLUT_IN-1:0] h_addr;
   logic [NUM_REG-1:0] reg_d;
   logic [NUM_REG-1:0] alt_src;

   cfg_chain #(.W(CW)) u_chain (
      .cfg_clk (cfg_clk),
      .cfg_en  (cfg_en),
      .cfg_din (cfg_din),
      .cfg     (cfg)
   );

   lut_table #(.N(FLUT_IN), .MUX_TREE(MUX_TREE)) u_f (
      .tbl  (cfg[F_LO +: FBITS]),
      .addr (f_in),
      .dout (f_out)
   );

   lut_table #(.N(FLUT_IN), .MUX_TREE(MUX_TREE)) u_g (
      .tbl  (cfg[G_LO +: FBITS]),
      .addr (g_in),
      .dout (g_out)
   );

   // steering: address bit 1 from F or pin, bit 2 from G or pin, rest direct
   always_comb begin
      h_addr    = h_in;
      h_addr[1] = cfg[STR_LO]     ? f_out : h_in[1];
      h_addr[2] = cfg[STR_LO + 1] ? g_out : h_in[2];
   end

   lut_table #(.N(HLUT_IN), .MUX_TREE(MUX_TREE)) u_h (
      .tbl  (cfg[H_LO +: HBITS]),
      .addr (h_addr),
      .dout (h_out)
   );

   assign alt_src = {g_out, f_out};

   generate
      for (genvar i = 0; i < NUM_REG; i++) begin : g_reg
         assign reg_d[i] = cfg[SRC_LO + i] ? h_out : alt_src[i];
         cell_reg u_reg (
            .clk  (clk),
            .rst  (rst),
            .hold (cfg_en),
            .ce   (ce[i]),
            .d    (reg_d[i]),
            .q    (q[i])
         );
      end
   endgenerate

   // R1
   f_func_chk: assert property (@(posedge clk) disable iff (rst) !cfg_en |-> (f_out == cfg[F_LO + f_in]));
   // R2
   g_func_chk: assert property (@(posedge clk) disable iff (rst) !cfg_en |-> (g_out == cfg[G_LO + g_in]));
   // R3
   h_pin_chk: assert property (@(posedge clk) disable iff (rst)
      (!cfg_en && !cfg[STR_LO] && !cfg[STR_LO + 1]) |-> (h_out == cfg[H_LO + h_in]));
endmodule

// File: tb/sim_lut_cell.sv
module sim_lut_cell;
   localparam int CW = 44;

   logic       clk = 1'b0;
   logic       cfg_clk;
   logic       rst, cfg_en, cfg_din;
   logic [3:0] f_in, g_in;
   logic [2:0] h_in;
   logic [1:0] ce;
   logic       f_out, g_out, h_out;
   logic [1:0] q;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;
   assign cfg_clk = clk;

   lut_cell u0 (
      .clk(clk), .rst(rst), .cfg_clk(cfg_clk), .cfg_en(cfg_en), .cfg_din(cfg_din),
      .f_in(f_in), .g_in(g_in), .h_in(h_in), .ce(ce),
      .f_out(f_out), .g_out(g_out), .h_out(h_out), .q(q)
   );

   function automatic bit m_f(logic [CW-1:0] c, logic [3:0] a);
      return c[a];
   endfunction
   function automatic bit m_g(logic [CW-1:0] c, logic [3:0] a);
      return c[16 + a];
   endfunction
   function automatic bit m_h(logic [CW-1:0] c, logic [3:0] fa, logic [3:0] ga, logic [2:0] hp);
      logic a1, a2;
      a1 = c[40] ? m_f(c, fa) : hp[1];
      a2 = c[41] ? m_g(c, ga) : hp[2];
      return c[32 + {a2, a1, hp[0]}];
   endfunction
   function automatic logic [1:0] m_d(logic [CW-1:0] c, logic [3:0] fa, logic [3:0] ga, logic [2:0] hp);
      logic [1:0] d;
      d[0] = c[42] ? m_h(c, fa, ga, hp) : m_f(c, fa);
      d[1] = c[43] ? m_h(c, fa, ga, hp) : m_g(c, ga);
      return d;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // R5 R9: shift MSB first; both enables high, registers must not move
   task automatic load(input logic [CW-1:0] v);
      logic [1:0] q_before;
      @(negedge clk);
      q_before = q;
      for (int i = CW - 1; i >= 0; i--) begin
         cfg_en  = 1'b1;
         cfg_din = v[i];
         ce      = 2'b11;
         f_in    = 4'($urandom);
         g_in    = 4'($urandom);
         @(negedge clk);
         chk(q == q_before, "R9 hold during load", 32'(q), 32'(q_before));
      end
      cfg_en  = 1'b0;
      cfg_din = 1'($urandom);
      ce      = 2'b00;
   endtask

   task automatic comb_check(input logic [CW-1:0] c, input string tag);
      f_in = 4'($urandom);
      g_in = 4'($urandom);
      h_in = 3'($urandom);
      #2;
      chk(f_out == m_f(c, f_in), {"R1 ", tag}, 32'(f_out), 32'(m_f(c, f_in)));
      chk(g_out == m_g(c, g_in), {"R2 ", tag}, 32'(g_out), 32'(m_g(c, g_in)));
      chk(h_out == m_h(c, f_in, g_in, h_in), {"R3 ", tag}, 32'(h_out), 32'(m_h(c, f_in, g_in, h_in)));
   endtask

   initial begin
      #(20 * 190000);
      chk(1'b0, "watchdog", 32'd0, 32'd1);
      finish_up();
   end

   initial begin
      logic [CW-1:0] cur;
      logic [1:0]    q_exp;
      logic [31:0]   tt;
      void'($urandom(32'd20240611));
      rst = 1'b1; cfg_en = 1'b0; cfg_din = 1'b0;
      f_in = '0; g_in = '0; h_in = '0; ce = 2'b11;
      repeat (3) @(negedge clk);
      chk(q == 2'b00, "R10 reset state", 32'(q), 32'd0);
      rst = 1'b0;
      ce  = 2'b00;

      // R5: single set bit at F entry 0 and H entry 7
      cur = '0;
      cur[0]  = 1'b1;
      cur[39] = 1'b1;
      load(cur);
      for (int a = 0; a < 16; a++) begin
         f_in = 4'(a); g_in = 4'(a); h_in = 3'b111;
         #2;
         chk(f_out == (a == 0), "R5 F bit order", 32'(f_out), 32'(a == 0));
         chk(g_out == 1'b0, "R5 G empty", 32'(g_out), 32'd0);
         chk(h_out == 1'b1, "R5 H top entry", 32'(h_out), 32'd1);
         @(negedge clk);
      end

      // R11: repeated random reloads
      for (int k = 0; k < 12; k++) begin
         cur = {12'($urandom), $urandom};
         load(cur);
         for (int t = 0; t < 24; t++) begin
            comb_check(cur, "random");
            @(negedge clk);
         end
         chk(f_out == m_f(cur, f_in), "R11 reload effective", 32'(f_out), 32'(m_f(cur, f_in)));
         // R7 R8: registers with random enables
         q_exp = q;
         for (int t = 0; t < 24; t++) begin
            f_in = 4'($urandom); g_in = 4'($urandom); h_in = 3'($urandom);
            ce   = 2'($urandom);
            for (int i = 0; i < 2; i++)
               if (ce[i]) q_exp[i] = m_d(cur, f_in, g_in, h_in)[i];
            @(negedge clk);
            chk(q == q_exp, "R7 R8 register update", 32'(q), 32'(q_exp));
         end
         ce = 2'b00;
      end

      // R6: toggling serial data with enable low
      for (int t = 0; t < 30; t++) begin
         cfg_din = 1'($urandom);
         @(negedge clk);
         comb_check(cur, "R6 din ignored");
      end

      // R4: any five-input function
      tt = $urandom;
      cur = '0;
      cur[15:0]  = tt[15:0];
      cur[31:16] = tt[31:16];
      for (int i = 0; i < 8; i++) cur[32 + i] = i[0] ? i[2] : i[1];
      cur[40] = 1'b1; cur[41] = 1'b1; cur[42] = 1'b1; cur[43] = 1'b1;
      load(cur);
      for (int x = 0; x < 32; x++) begin
         f_in = 4'(x); g_in = 4'(x);
         h_in = {2'($urandom), x[4]};
         #2;
         chk(h_out == tt[x], "R4 five-input", 32'(h_out), 32'(tt[x]));
         @(negedge clk);
      end

      // R10: reset wins over enables
      ce = 2'b11;
      f_in = 4'd0; g_in = 4'd0; h_in = 3'b000;
      rst = 1'b1;
      @(negedge clk);
      chk(q == 2'b00, "R10 reset priority", 32'(q), 32'd0);
      rst = 1'b0;
      @(negedge clk);
      chk(q == m_d(cur, 4'd0, 4'd0, 3'b000), "R7 after reset", 32'(q), 32'(m_d(cur, 4'd0, 4'd0, 3'b000)));

      finish_up();
   end
endmodule